// File: doc/BRIEF.md
# Dual-Clock Inter-Processor Mailbox

This block connects a main processor and an audio processor through four byte-wide message ports. Both sides use the same port numbers, but each port holds two separate bytes, one for each direction. When a side writes a port, it loads the byte that the other side will read. When a side reads a port, it sees only what the opposite processor last wrote there, and never its own writes. Any handshake between the processors is built in software on top of these ports.

The two processors run from clocks with no fixed relation to each other. Each written byte is held stable in the writer's clock domain. A toggle bit announces the write, and that bit passes through a two-flop synchronizer before the reader's copy of the byte is updated. The audio side also has two clear inputs. Each one zeroes the bytes that the audio side reads from one pair of ports.

Top module: `mbox_bridge`

## Requirements
- R1: The main side selects a port with `m_addr` 0x40 to 0x43. Address bits [1:0] give the port number 0 to 3.
- R2: The audio side selects a port with `a_addr` 0xF4 to 0xF7. Address bits [1:0] give the port number 0 to 3.
- R3: While `m_rd` is high and the address is in the window, `m_rdata` shows the byte the audio side last wrote to that port. A main-side write never appears on `m_rdata`.
- R4: While `a_rd` is high and the address is in the window, `a_rdata` shows the byte the main side last wrote to that port. An audio-side write never appears on `a_rdata`.
- R5: A write takes effect at the writer's rising clock edge. The reader sees the new byte no later than its third rising clock edge after that write edge. This holds when writes to the same port are spaced further apart than that.
- R6: Holding `a_clr[0]` high at an audio clock edge zeroes the bytes that the audio side reads from ports 0 and 1. `a_clr[1]` does the same for ports 2 and 3. The clear takes effect at that edge and wins over a write arriving at the same edge. Bytes flowing toward the main side are not affected.
- R7: A read never changes any stored byte. Read data is zero whenever the read strobe is low or the address is outside the window.
- R8: After reset, every read returns zero.
- R9: A write strobe with an address outside the side's window changes no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk | input | 1 | Main processor clock |
| m_rst_n | input | 1 | Main-domain reset, active low |
| m_addr | input | 8 | Main-side address within the I/O page |
| m_wr | input | 1 | Main-side write strobe |
| m_wdata | input | 8 | Main-side write data |
| m_rd | input | 1 | Main-side read strobe |
| m_rdata | output | 8 | Byte last written by the audio side |
| a_clk | input | 1 | Audio processor clock |
| a_rst_n | input | 1 | Audio-domain reset, active low |
| a_addr | input | 8 | Audio-side address |
| a_wr | input | 1 | Audio-side write strobe |
| a_wdata | input | 8 | Audio-side write data |
| a_rd | input | 1 | Audio-side read strobe |
| a_rdata | output | 8 | Byte last written by the main side |
| a_clr | input | 2 | Clears the audio-side read bytes of ports 0-1 (bit 0) and 2-3 (bit 1) |

## Verification
A lost or doubled toggle can be seen at the ports. The reader's byte either never updates, or it updates without a write, within three reader clocks. A swap of the per-direction storage shows a side's own write on its own read data after the same delay. A clear that hits the wrong pair, or the wrong direction, shows up at the next audio-side read, one clock after the clear. The bench keeps a model of both directions. It compares every port on both sides after each burst of random writes and clears.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int unsigned MB_NPORTS = 4;
    localparam int unsigned MB_DW     = 8;
    localparam int unsigned MB_AW     = 8;
    localparam int unsigned MB_GRP    = 2;
endpackage

// File: rtl/mbox_tx.sv
module mbox_tx #(
    parameter int unsigned NP   = 4,
    parameter int unsigned DW   = 8,
    parameter int unsigned SELW = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SELW-1:0]        wr_sel,
    input  logic [DW-1:0]          wr_data,
    output logic [NP-1:0][DW-1:0]  hold_o,
    output logic [NP-1:0]          tog_o
);
    typedef struct packed {
        logic [NP-1:0][DW-1:0] hold;
        logic [NP-1:0]         tog;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.hold[wr_sel] = wr_data;
            st_d.tog[wr_sel]  = ~st_q.tog[wr_sel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;
    assign tog_o  = st_q.tog;
endmodule

// File: rtl/mbox_rx.sv
module mbox_rx #(
    parameter int unsigned NP  = 4,
    parameter int unsigned DW  = 8,
    parameter int unsigned GRP = 2,
    localparam int unsigned NG = NP / GRP
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NP-1:0][DW-1:0]  src_hold,
    input  logic [NP-1:0]          src_tog,
    input  logic [NG-1:0]          clr_grp,
    output logic [NP-1:0][DW-1:0]  vis_o,
    output logic [NP-1:0]          upd_o
);
    typedef struct packed {
        logic [NP-1:0]         s1;
        logic [NP-1:0]         s2;
        logic [NP-1:0]         seen;
        logic [NP-1:0][DW-1:0] vis;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic [NP-1:0] upd;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = src_tog;
        st_d.s2   = st_q.s1;
        st_d.seen = st_q.s2;
        upd       = st_q.s2 ^ st_q.seen;
        for (int p = 0; p < int'(NP); p++) begin
            if (upd[p])            st_d.vis[p] = src_hold[p];
            if (clr_grp[p / GRP])  st_d.vis[p] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vis_o = st_q.vis;
    assign upd_o = upd;
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
    import mbox_pkg::*;
#(
    parameter int unsigned NPORTS = MB_NPORTS,
    parameter int unsigned DW     = MB_DW,
    parameter int unsigned AW     = MB_AW,
    parameter int unsigned GRP    = MB_GRP,
    parameter logic [AW-1:0] M_BASE = 8'h40,
    parameter logic [AW-1:0] A_BASE = 8'hF4,
    localparam int unsigned SELW = $clog2(NPORTS),
    localparam int unsigned NG   = NPORTS / GRP
) (
    input  logic          m_clk,
    input  logic          m_rst_n,
    input  logic [AW-1:0] m_addr,
    input  logic          m_wr,
    input  logic [DW-1:0] m_wdata,
    input  logic          m_rd,
    output logic [DW-1:0] m_rdata,
    input  logic          a_clk,
    input  logic          a_rst_n,
    input  logic [AW-1:0] a_addr,
    input  logic          a_wr,
    input  logic [DW-1:0] a_wdata,
    input  logic          a_rd,
    output logic [DW-1:0] a_rdata,
    input  logic [NG-1:0] a_clr
);
    localparam logic [AW-SELW-1:0] M_PAGE = M_BASE[AW-1:SELW];
    localparam logic [AW-SELW-1:0] A_PAGE = A_BASE[AW-1:SELW];

    logic                       m_hit, a_hit, m_wr_hit, a_wr_hit;
    logic [NPORTS-1:0][DW-1:0]  m_hold, a_hold, m_vis, a_vis;
    logic [NPORTS-1:0]          m_tog, a_tog, m_upd, a_upd;

    assign m_hit    = (m_addr[AW-1:SELW] == M_PAGE);
    assign a_hit    = (a_addr[AW-1:SELW] == A_PAGE);
    assign m_wr_hit = m_wr & m_hit;
    assign a_wr_hit = a_wr & a_hit;

    // main writes, audio reads
    mbox_tx #(.NP(NPORTS), .DW(DW), .SELW(SELW)) u_tx_m (
        .clk(m_clk), .rst_n(m_rst_n), .wr_en(m_wr_hit),
        .wr_sel(m_addr[SELW-1:0]), .wr_data(m_wdata),
        .hold_o(m_hold), .tog_o(m_tog)
    );
    mbox_rx #(.NP(NPORTS), .DW(DW), .GRP(GRP)) u_rx_a (
        .clk(a_clk), .rst_n(a_rst_n), .src_hold(m_hold), .src_tog(m_tog),
        .clr_grp(a_clr), .vis_o(a_vis), .upd_o(a_upd)
    );

    // audio writes, main reads
    mbox_tx #(.NP(NPORTS), .DW(DW), .SELW(SELW)) u_tx_a (
        .clk(a_clk), .rst_n(a_rst_n), .wr_en(a_wr_hit),
        .wr_sel(a_addr[SELW-1:0]), .wr_data(a_wdata),
        .hold_o(a_hold), .tog_o(a_tog)
    );
    mbox_rx #(.NP(NPORTS), .DW(DW), .GRP(GRP)) u_rx_m (
        .clk(m_clk), .rst_n(m_rst_n), .src_hold(a_hold), .src_tog(a_tog),
        .clr_grp('0), .vis_o(m_vis), .upd_o(m_upd)
    );

    assign m_rdata = (m_rd && m_hit) ? m_vis[m_addr[SELW-1:0]] : '0;
    assign a_rdata = (a_rd && a_hit) ? a_vis[a_addr[SELW-1:0]] : '0;
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
    parameter int unsigned NP  = 4,
    parameter int unsigned DW  = 8,
    parameter int unsigned GRP = 2,
    parameter int unsigned NG  = 2
) (
    input logic                  m_clk,
    input logic                  m_rst_n,
    input logic                  a_clk,
    input logic                  a_rst_n,
    input logic [NP-1:0][DW-1:0] m_vis,
    input logic [NP-1:0][DW-1:0] a_vis,
    input logic [NP-1:0]         m_upd,
    input logic [NP-1:0]         a_upd,
    input logic [NP-1:0]         m_tog,
    input logic [NP-1:0]         a_tog,
    input logic                  m_wr_hit,
    input logic                  a_wr_hit,
    input logic [NG-1:0]         a_clr
);
    for (genvar g = 0; g < int'(NG); g++) begin : g_clr
        a_r6_clear_pair: assert property (@(posedge a_clk) disable iff (!a_rst_n)
            a_clr[g] |=> (a_vis[g*GRP] == '0 && a_vis[g*GRP+GRP-1] == '0));
    end

    a_r7_audio_copy_moves_only_on_event: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        !$stable(a_vis) |-> $past((|a_upd) || (|a_clr)));

    a_r7_main_copy_moves_only_on_event: assert property (@(posedge m_clk) disable iff (!m_rst_n)
        !$stable(m_vis) |-> $past(|m_upd));

    a_r5_main_write_one_toggle: assert property (@(posedge m_clk) disable iff (!m_rst_n)
        m_wr_hit |=> $countones(m_tog ^ $past(m_tog)) == 1);

    a_r5_audio_write_one_toggle: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        a_wr_hit |=> $countones(a_tog ^ $past(a_tog)) == 1);

    a_r9_main_no_write_no_toggle: assert property (@(posedge m_clk) disable iff (!m_rst_n)
        !m_wr_hit |=> $stable(m_tog));
endmodule

bind mbox_bridge mbox_chk #(.NP(NPORTS), .DW(DW), .GRP(GRP), .NG(NG)) u_chk (
    .m_clk(m_clk), .m_rst_n(m_rst_n), .a_clk(a_clk), .a_rst_n(a_rst_n),
    .m_vis(m_vis), .a_vis(a_vis), .m_upd(m_upd), .a_upd(a_upd),
    .m_tog(m_tog), .a_tog(a_tog), .m_wr_hit(m_wr_hit), .a_wr_hit(a_wr_hit),
    .a_clr(a_clr)
);

// File: tb/mbox_bridge_bench.sv
module mbox_bridge_bench;
    localparam int M_PERIOD = 10;
    localparam int A_PERIOD = 14;

    logic       m_clk = 1'b0, a_clk = 1'b0;
    logic       m_rst_n = 1'b0, a_rst_n = 1'b0;
    logic [7:0] m_addr = '0, a_addr = '0, m_wdata = '0, a_wdata = '0;
    logic       m_wr = 1'b0, m_rd = 1'b0, a_wr = 1'b0, a_rd = 1'b0;
    logic [1:0] a_clr = '0;
    wire  [7:0] m_rdata, a_rdata;

    int n_vec = 0, n_bad = 0;
    logic [7:0] exp_m2a [4];
    logic [7:0] exp_a2m [4];

    always #(M_PERIOD/2) m_clk = ~m_clk;
    always #(A_PERIOD/2) a_clk = ~a_clk;

    mbox_bridge u_mbox_bridge (
        .m_clk(m_clk), .m_rst_n(m_rst_n), .m_addr(m_addr), .m_wr(m_wr),
        .m_wdata(m_wdata), .m_rd(m_rd), .m_rdata(m_rdata),
        .a_clk(a_clk), .a_rst_n(a_rst_n), .a_addr(a_addr), .a_wr(a_wr),
        .a_wdata(a_wdata), .a_rd(a_rd), .a_rdata(a_rdata), .a_clr(a_clr)
    );

    function automatic bit m_in_win(input logic [7:0] ad);
        return ad[7:2] == 6'h10;
    endfunction
    function automatic bit a_in_win(input logic [7:0] ad);
        return ad[7:2] == 6'h3D;
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic m_write(input logic [7:0] ad, input logic [7:0] d);
        @(negedge m_clk);
        m_addr = ad; m_wdata = d; m_wr = 1'b1;
        @(negedge m_clk);
        m_wr = 1'b0;
        if (m_in_win(ad)) exp_m2a[ad[1:0]] = d;
    endtask

    task automatic a_write(input logic [7:0] ad, input logic [7:0] d);
        @(negedge a_clk);
        a_addr = ad; a_wdata = d; a_wr = 1'b1;
        @(negedge a_clk);
        a_wr = 1'b0;
        if (a_in_win(ad)) exp_a2m[ad[1:0]] = d;
    endtask

    task automatic m_read(input logic [7:0] ad, input logic [7:0] exp, input string tag);
        @(negedge m_clk);
        m_addr = ad; m_rd = 1'b1;
        #1 chk(m_rdata, exp, tag);
        m_rd = 1'b0;
    endtask

    task automatic a_read(input logic [7:0] ad, input logic [7:0] exp, input string tag);
        @(negedge a_clk);
        a_addr = ad; a_rd = 1'b1;
        #1 chk(a_rdata, exp, tag);
        a_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge a_clk);
        repeat (5) @(negedge m_clk);
    endtask

    task automatic check_all(input string tag);
        for (int p = 0; p < 4; p++) begin
            m_read(8'h40 + 8'(p), exp_a2m[p], {tag, " R3 main read"});
            a_read(8'hF4 + 8'(p), exp_m2a[p], {tag, " R4 audio read"});
        end
    endtask

    initial begin
        #(M_PERIOD * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240415));
        for (int p = 0; p < 4; p++) begin exp_m2a[p] = '0; exp_a2m[p] = '0; end
        #(M_PERIOD * 5);
        @(negedge m_clk) m_rst_n = 1'b1;
        @(negedge a_clk) a_rst_n = 1'b1;
        settle();

        // R8: all zero after reset
        check_all("R8 reset");

        // R1/R4: main write to port 1 reaches audio, not main
        m_write(8'h41, 8'h5A); settle();
        a_read(8'hF5, 8'h5A, "R1 R4 port1 to audio");
        m_read(8'h41, 8'h00, "R3 own write hidden");

        // R2/R3: audio write to port 2 reaches main
        a_write(8'hF6, 8'hC3); settle();
        m_read(8'h42, 8'hC3, "R2 R3 port2 to main");
        a_read(8'hF6, 8'h00, "R4 own write hidden");

        // both sides write port 3 together
        fork
            m_write(8'h43, 8'h11);
            a_write(8'hF7, 8'h22);
        join
        settle();
        check_all("R3 R4 same port both sides");

        // R5: visible by the third audio edge after the write edge
        m_write(8'h40, 8'h77);
        repeat (3) @(negedge a_clk);
        a_read(8'hF4, 8'h77, "R5 latency main to audio");
        a_write(8'hF5, 8'h99);
        repeat (3) @(negedge m_clk);
        m_read(8'h41, 8'h99, "R5 latency audio to main");
        settle();

        // R9: writes outside the windows
        m_write(8'h44, 8'hEE); m_write(8'h3F, 8'hEE); m_write(8'hF4, 8'hEE);
        a_write(8'hF3, 8'hDD); a_write(8'hF8, 8'hDD); a_write(8'h40, 8'hDD);
        settle();
        check_all("R9 out of window");

        // R7: strobe low or address outside gives zero; reads keep contents
        @(negedge m_clk); m_addr = 8'h42; m_rd = 1'b0;
        #1 chk(m_rdata, 8'h00, "R7 main strobe low");
        @(negedge a_clk); a_addr = 8'hF4; a_rd = 1'b0;
        #1 chk(a_rdata, 8'h00, "R7 audio strobe low");
        m_read(8'h44, 8'h00, "R7 main read outside");
        a_read(8'hF8, 8'h00, "R7 audio read outside");
        check_all("R7 repeat A");
        check_all("R7 repeat B");

        // R6: pair clears
        for (int p = 0; p < 4; p++) m_write(8'h40 + 8'(p), 8'hA0 + 8'(p));
        for (int p = 0; p < 4; p++) a_write(8'hF4 + 8'(p), 8'h50 + 8'(p));
        settle();
        @(negedge a_clk) a_clr = 2'b01;
        @(negedge a_clk) a_clr = 2'b00;
        exp_m2a[0] = '0; exp_m2a[1] = '0;
        check_all("R6 clear ports 0-1");
        @(negedge a_clk) a_clr = 2'b10;
        @(negedge a_clk) a_clr = 2'b00;
        exp_m2a[2] = '0; exp_m2a[3] = '0;
        check_all("R6 clear ports 2-3");

        // random mix
        for (int it = 0; it < 160; it++) begin
            int kind;
            logic [7:0] ad, d;
            kind = int'($urandom % 7);
            d    = 8'($urandom);
            if (kind < 3) begin
                ad = ($urandom % 6 == 0) ? 8'($urandom) : (8'h40 + 8'($urandom % 4));
                m_write(ad, d);
            end else if (kind < 6) begin
                ad = ($urandom % 6 == 0) ? 8'($urandom) : (8'hF4 + 8'($urandom % 4));
                a_write(ad, d);
            end else begin
                logic [1:0] c;
                c = 2'($urandom);
                @(negedge a_clk) a_clr = c;
                @(negedge a_clk) a_clr = 2'b00;
                if (c[0]) begin exp_m2a[0] = '0; exp_m2a[1] = '0; end
                if (c[1]) begin exp_m2a[2] = '0; exp_m2a[3] = '0; end
            end
            settle();
            if (it % 8 == 7) check_all("R1 R2 R6 R9 random");
        end
        check_all("random final");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule